// File: doc/BRIEF.md
# Cyclic Housekeeping Acquisition Controller

This block is a slave on a small internal register bus. It sweeps an analogue multiplexer through all sixteen of its inputs and starts a successive-approximation converter once for each input. Only the top nine bits of each conversion result are kept, and each one is pushed into an on-chip FIFO. A single write from the host launches a full sweep. While the sweep runs, a status bit stays high. When the sweep is finished, the host drains the samples through a data register.

Each time the multiplexer moves to a new input, the sequencer waits a fixed number of clock cycles so that the analogue path can settle. Only then does it pulse the converter start. The converter answers with a busy level, and its result is taken on the cycle in which busy drops. The status word also reports the FIFO condition and a timer clock source flag that comes in from outside the block.

Top module: `hk_acq_ctrl`

## Requirements
- R1: A write to address 0 with `bus_wdata_i` = 1, made while idle, starts one sweep, and status bit 0 (in progress) reads 1 on the following status read. A write to address 0 with `bus_wdata_i` = 0 starts nothing.
- R2: In each sweep, channels 0 to 15 are placed on `mux_sel_o` in ascending order, and each one is converted exactly once.
- R3: `adc_start_o` is a one-cycle pulse. It is asserted exactly SETTLE_CYC (32) cycles after `mux_sel_o` takes a new channel; for channel 0 the count runs from the clock edge that accepts the start write.
- R4: After a start pulse, the block waits for `adc_busy_i` to rise and then to fall. It captures `adc_data_i` in the cycle in which `adc_busy_i` is low again.
- R5: Each stored sample is `adc_data_i[11:3]`. A read of address 2 removes the oldest sample and returns it zero-extended to 16 bits on `bus_rdata_o`, one cycle after the read strobe.
- R6: Status bit 0 clears only once all 16 samples of the sweep are in the FIFO.
- R7: In the status word at address 1, bit 1 is FIFO empty, bit 2 is FIFO not-empty and bit 3 is FIFO full (32 entries). All other bits not named in R8 read 0.
- R8: Status bit 4 follows `obt_ext_clk_i` (1 means the time counter runs from an external clock).
- R9: A start write made while a sweep is in progress is ignored. The running sweep carries on unchanged, and it still stores exactly 16 samples.
- R10: A sample that arrives while the FIFO is full is dropped. The 32 entries already stored are kept in order.
- R11: A read of address 2 when the FIFO is empty returns 0 and leaves the status unchanged.
- R12: After reset the sequencer is idle, `mux_sel_o` is 0, `adc_start_o` is 0 and the status word reads 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address: 0 start, 1 status, 2 sample data |
| bus_wdata_i | input | 1 | Written go bit for the start register |
| bus_rdata_o | output | 16 | Registered read data |
| obt_ext_clk_i | input | 1 | Time counter clock source flag |
| mux_sel_o | output | 4 | Analogue multiplexer channel select |
| adc_start_o | output | 1 | Converter start pulse |
| adc_busy_i | input | 1 | Converter busy |
| adc_data_i | input | 12 | Converter result |

## Verification
The bench builds the block with its default parameters: 16 channels, a 12-bit converter, 9-bit samples, a 32-entry FIFO and 32 settling cycles. With these values, two unread sweeps fill the FIFO exactly, so a third sweep lands on a full FIFO, and the drop and keep behaviour on overflow can be checked within a few thousand cycles. A converter model drives a deliberately wrong value while busy is high, and it uses patterns whose three low bits are set. This shows both when the result is captured and that the low bits are discarded.

// File: rtl/hk_acq_pkg.sv
package hk_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_START,
    ST_WAIT_BUSY,
    ST_CONV
  } seq_state_e;

  // register addresses
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_DATA = 2;

  // status word bit positions
  localparam int unsigned STAT_BUSY    = 0;
  localparam int unsigned STAT_EMPTY   = 1;
  localparam int unsigned STAT_NEMPTY  = 2;
  localparam int unsigned STAT_FULL    = 3;
  localparam int unsigned STAT_EXT_CLK = 4;

endpackage

// File: rtl/hk_acq_seq.sv
module hk_acq_seq
  import hk_acq_pkg::*;
#(
  parameter int unsigned N_CH       = 16,
  parameter int unsigned ADC_W      = 12,
  parameter int unsigned SMP_W      = 9,
  parameter int unsigned SETTLE_CYC = 32,
  localparam int unsigned CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adc_busy_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             busy_o,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic             adc_start_o,
  output logic             push_o,
  output logic [SMP_W-1:0] push_data_o
);

  seq_state_e       state_q;
  logic [CH_W-1:0]  ch_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_ch;
  logic             settled;

  assign last_ch = (ch_q == CH_W'(N_CH - 1));
  assign settled = (cnt_q == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ch_q    <= '0;
            cnt_q   <= '0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settled) state_q <= ST_START;
          else         cnt_q   <= cnt_q + 1'b1;
        end
        ST_START: state_q <= ST_WAIT_BUSY;
        ST_WAIT_BUSY: begin
          if (adc_busy_i) state_q <= ST_CONV;
        end
        ST_CONV: begin
          if (!adc_busy_i) begin
            if (last_ch) begin
              state_q <= ST_IDLE;
            end else begin
              ch_q    <= ch_q + 1'b1;
              cnt_q   <= '0;
              state_q <= ST_SETTLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mux_sel_o   = ch_q;
  assign adc_start_o = (state_q == ST_START);
  assign push_o      = (state_q == ST_CONV) && !adc_busy_i;

  // keep the top SMP_W bits of the result, pad if the converter is narrower
  generate
    if (ADC_W > SMP_W) begin : g_trunc
      logic [ADC_W-SMP_W-1:0] unused_lsb;
      assign unused_lsb  = adc_data_i[ADC_W-SMP_W-1:0];
      assign push_data_o = adc_data_i[ADC_W-1 -: SMP_W];
    end else if (ADC_W == SMP_W) begin : g_same
      assign push_data_o = adc_data_i;
    end else begin : g_pad
      assign push_data_o = {adc_data_i, {(SMP_W-ADC_W){1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/hk_acq_fifo.sv
module hk_acq_fifo #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o
);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign do_push = push_i && !full_o;   // overflow drops the sample
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      unique case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rptr_q];
  assign level_o = level_q;

endmodule

// File: rtl/hk_acq_regs.sv
module hk_acq_regs
  import hk_acq_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 2,
  parameter int unsigned SMP_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             acq_busy_i,
  input  logic             fifo_empty_i,
  input  logic             fifo_full_i,
  input  logic [SMP_W-1:0] fifo_head_i,
  input  logic             obt_ext_clk_i,
  output logic             start_o,
  output logic             pop_o
);

  logic          sel_ctrl, sel_stat, sel_data;
  logic [DW-1:0] status_w;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;

  assign sel_ctrl = (addr_i == AW'(ADDR_CTRL));
  assign sel_stat = (addr_i == AW'(ADDR_STAT));
  assign sel_data = (addr_i == AW'(ADDR_DATA));

  // raw request; the sequencer accepts it only when idle
  assign start_o = wr_i && sel_ctrl && wdata_i;
  assign pop_o   = rd_i && sel_data && !fifo_empty_i;

  always_comb begin
    status_w               = '0;
    status_w[STAT_BUSY]    = acq_busy_i;
    status_w[STAT_EMPTY]   = fifo_empty_i;
    status_w[STAT_NEMPTY]  = !fifo_empty_i;
    status_w[STAT_FULL]    = fifo_full_i;
    status_w[STAT_EXT_CLK] = obt_ext_clk_i;
  end

  always_comb begin
    rdata_d = '0;
    if (rd_i) begin
      if (sel_stat)                        rdata_d = status_w;
      else if (sel_data && !fifo_empty_i)  rdata_d = DW'(fifo_head_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/hk_acq_ctrl.sv
module hk_acq_ctrl #(
  parameter int unsigned N_CH       = 16,
  parameter int unsigned ADC_W      = 12,
  parameter int unsigned SMP_W      = 9,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned SETTLE_CYC = 32,
  parameter int unsigned BUS_DW     = 16,
  parameter int unsigned BUS_AW     = 2,
  localparam int unsigned CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              obt_ext_clk_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic              adc_start_o,
  input  logic              adc_busy_i,
  input  logic [ADC_W-1:0]  adc_data_i
);

  logic             start_req;
  logic             acq_busy;
  logic             push;
  logic [SMP_W-1:0] push_data;
  logic             pop;
  logic [SMP_W-1:0] fifo_head;
  logic             fifo_empty;
  logic             fifo_full;
  logic [LVL_W-1:0] fifo_level;

  hk_acq_regs #(
    .DW    (BUS_DW),
    .AW    (BUS_AW),
    .SMP_W (SMP_W)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (bus_wr_i),
    .rd_i          (bus_rd_i),
    .addr_i        (bus_addr_i),
    .wdata_i       (bus_wdata_i),
    .rdata_o       (bus_rdata_o),
    .acq_busy_i    (acq_busy),
    .fifo_empty_i  (fifo_empty),
    .fifo_full_i   (fifo_full),
    .fifo_head_i   (fifo_head),
    .obt_ext_clk_i (obt_ext_clk_i),
    .start_o       (start_req),
    .pop_o         (pop)
  );

  hk_acq_seq #(
    .N_CH       (N_CH),
    .ADC_W      (ADC_W),
    .SMP_W      (SMP_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_req),
    .adc_busy_i  (adc_busy_i),
    .adc_data_i  (adc_data_i),
    .busy_o      (acq_busy),
    .mux_sel_o   (mux_sel_o),
    .adc_start_o (adc_start_o),
    .push_o      (push),
    .push_data_o (push_data)
  );

  hk_acq_fifo #(
    .DW    (SMP_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (fifo_head),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full),
    .level_o     (fifo_level)
  );

endmodule

// File: rtl/hk_acq_chk.sv
module hk_acq_chk #(
  parameter int unsigned N_CH       = 16,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned SETTLE_CYC = 32,
  localparam int unsigned CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned GAP_W     = $clog2(SETTLE_CYC + 2) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CH_W-1:0]  mux_sel_i,
  input logic             adc_start_i,
  input logic             acq_busy_i,
  input logic             start_req_i,
  input logic             push_i,
  input logic             pop_i,
  input logic             fifo_full_i,
  input logic [LVL_W-1:0] fifo_level_i
);

  // cycles since the last channel change or sweep launch
  logic [CH_W-1:0]  mux_q;
  logic             busy_q;
  logic [GAP_W-1:0] gap_q;
  logic             chg;

  assign chg = (mux_sel_i != mux_q) || (acq_busy_i && !busy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q  <= '0;
      busy_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      mux_q  <= mux_sel_i;
      busy_q <= acq_busy_i;
      if (chg)             gap_q <= GAP_W'(1);
      else if (~&gap_q)    gap_q <= gap_q + 1'b1;
    end
  end

  assert_settle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_i |-> (gap_q >= GAP_W'(SETTLE_CYC)));

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_i |=> !adc_start_i);

  assert_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_i != $past(mux_sel_i)) |->
      ((mux_sel_i == '0) || (mux_sel_i == CH_W'($past(mux_sel_i) + 1'b1))));

  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_i && acq_busy_i) |=>
      (acq_busy_i || $past(push_i)) &&
      ((mux_sel_i == $past(mux_sel_i)) || (mux_sel_i == CH_W'($past(mux_sel_i) + 1'b1))));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_i && push_i && !pop_i) |=> (fifo_level_i == LVL_W'(FIFO_DEPTH)));

  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acq_busy_i) |-> $past(push_i));

endmodule

bind hk_acq_ctrl hk_acq_chk #(
  .N_CH       (N_CH),
  .FIFO_DEPTH (FIFO_DEPTH),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mux_sel_i    (mux_sel_o),
  .adc_start_i  (adc_start_o),
  .acq_busy_i   (acq_busy),
  .start_req_i  (start_req),
  .push_i       (push),
  .pop_i        (pop),
  .fifo_full_i  (fifo_full),
  .fifo_level_i (fifo_level)
);

// File: tb/hk_acq_ctrl_tb.sv
`timescale 1ns/1ps
module hk_acq_ctrl_tb;

  localparam int N_CH       = 16;
  localparam int SETTLE_CYC = 32;
  localparam int DEPTH      = 32;
  localparam int CONV_CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wdata = 1'b0;
  logic [15:0] bus_rdata;
  logic        obt_ext = 1'b0;
  logic [3:0]  mux_sel;
  logic        adc_start;
  logic        adc_busy = 1'b0;
  logic [11:0] adc_data = '0;

  int adc_mode = 0;
  int adc_run  = 0;
  int n_chk = 0, n_fail = 0;
  int m_chk = 0, m_fail = 0;

  always #2 clk = ~clk;

  hk_acq_ctrl u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .bus_wr_i      (bus_wr),
    .bus_rd_i      (bus_rd),
    .bus_addr_i    (bus_addr),
    .bus_wdata_i   (bus_wdata),
    .bus_rdata_o   (bus_rdata),
    .obt_ext_clk_i (obt_ext),
    .mux_sel_o     (mux_sel),
    .adc_start_o   (adc_start),
    .adc_busy_i    (adc_busy),
    .adc_data_i    (adc_data)
  );

  function automatic logic [11:0] exp_data(int mode, int ch, int run);
    case (mode)
      1:       return 12'hFFF;
      2:       return 12'h007;
      default: return 12'((ch * 243 + run * 273 + 7) & 'hFFF);
    endcase
  endfunction

  function automatic logic [15:0] exp_word(int mode, int ch, int run);
    logic [11:0] d;
    d = exp_data(mode, ch, run);
    return {7'b0, d[11:3]};
  endfunction

  // converter model; shows a wrong value while busy (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        @(posedge clk); #1;
        adc_busy = 1'b1;
        adc_data = ~exp_data(adc_mode, int'(mux_sel), adc_run);
        repeat (CONV_CYC) @(posedge clk);
        #1;
        adc_data = exp_data(adc_mode, int'(mux_sel), adc_run);
        adc_busy = 1'b0;
      end
    end
  end

  // settle gap (R3) and channel order (R2) monitor
  initial begin
    logic [3:0] prev_mux;
    int gap, conv_idx;
    prev_mux = '0; gap = 0; conv_idx = 0;
    forever begin
      @(negedge clk);
      if (mux_sel != prev_mux) gap = 0;
      else if (bus_wr && bus_addr == 2'd0 && bus_wdata) gap = -1;
      else gap++;
      prev_mux = mux_sel;
      if (adc_start) begin
        m_chk++;
        if (gap != SETTLE_CYC) begin
          m_fail++;
          $display("FAIL R3 settle gap: actual %0d expected %0d", gap, SETTLE_CYC);
        end
        m_chk++;
        if (int'(mux_sel) != conv_idx % N_CH) begin
          m_fail++;
          $display("FAIL R2 channel order: actual %0d expected %0d", mux_sel, conv_idx % N_CH);
        end
        conv_idx++;
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(string req);
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      bus_read(2'd1, s);
      if (!s[0]) return;
    end
    check(req, 16'hDEAD, 16'h0000);
  endtask

  task automatic run_sweep(int mode, int run);
    logic [15:0] s;
    adc_mode = mode; adc_run = run;
    bus_write(2'd0, 1'b1);
    bus_read(2'd1, s);
    check("R1 in-progress after start", 16'(s[0]), 16'h1);
    wait_done("R6 sweep timeout");
  endtask

  task automatic drain_check(string req, int mode, int run);
    logic [15:0] d;
    for (int c = 0; c < N_CH; c++) begin
      bus_read(2'd2, d);
      check(req, d, exp_word(mode, c, run));
    end
  endtask

  task automatic t_reset;
    logic [15:0] s;
    check("R12 mux after reset", 16'(mux_sel), 16'h0);
    check("R12 start after reset", 16'(adc_start), 16'h0);
    bus_read(2'd1, s);
    check("R12 status after reset", s, 16'h0002);
  endtask

  task automatic t_basic;
    logic [15:0] s, d;
    run_sweep(0, 1);
    bus_read(2'd1, s);
    check("R6 status after sweep", s, 16'h0004);
    drain_check("R5 sample run1", 0, 1);
    bus_read(2'd1, s);
    check("R7 empty after drain", s, 16'h0002);
    bus_read(2'd2, d);
    check("R11 empty read", d, 16'h0000);
    bus_read(2'd1, s);
    check("R11 status unchanged", s, 16'h0002);
  endtask

  task automatic t_no_go;
    logic [15:0] s;
    bus_write(2'd0, 1'b0);
    repeat (3) @(posedge clk);
    bus_read(2'd1, s);
    check("R1 write of zero starts nothing", s, 16'h0002);
  endtask

  task automatic t_ignore;
    logic [15:0] s, d;
    adc_mode = 0; adc_run = 2;
    bus_write(2'd0, 1'b1);
    repeat (3) @(negedge clk);
    while (!adc_busy) @(negedge clk);
    bus_write(2'd0, 1'b1);   // must be ignored (R9)
    wait_done("R9 sweep timeout");
    drain_check("R9 sweep unchanged", 0, 2);
    bus_read(2'd2, d);
    check("R9 exactly 16 samples", d, 16'h0000);
    bus_read(2'd1, s);
    check("R9 no second sweep", s, 16'h0002);
  endtask

  task automatic t_trunc;
    logic [15:0] s, d;
    run_sweep(1, 0);
    drain_check("R5 all-ones truncation", 1, 0);
    run_sweep(2, 0);
    for (int c = 0; c < N_CH - 1; c++) begin
      bus_read(2'd2, d);
      check("R5 low bits dropped", d, 16'h0000);
    end
    bus_read(2'd1, s);
    check("R7 one left not-empty", s, 16'h0004);
    bus_read(2'd2, d);
    bus_read(2'd1, s);
    check("R7 empty after 16", s, 16'h0002);
  endtask

  task automatic t_full;
    logic [15:0] s;
    run_sweep(0, 3);
    run_sweep(0, 4);
    bus_read(2'd1, s);
    check("R7 full after two sweeps", s, 16'h000C);
    run_sweep(0, 5);
    bus_read(2'd1, s);
    check("R10 still full", s, 16'h000C);
    drain_check("R10 first sweep kept", 0, 3);
    drain_check("R10 second sweep kept", 0, 4);
    bus_read(2'd1, s);
    check("R10 third sweep dropped", s, 16'h0002);
  endtask

  task automatic t_ext_clk;
    logic [15:0] s;
    obt_ext = 1'b1;
    bus_read(2'd1, s);
    check("R8 external clock flag", s, 16'h0012);
    obt_ext = 1'b0;
    bus_read(2'd1, s);
    check("R8 internal clock flag", s, 16'h0002);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk + 1, n_fail + m_fail + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_no_go();
    t_ignore();
    t_trunc();
    t_full();
    t_ext_clk();
    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk, n_fail + m_fail);
    $finish;
  end

endmodule